// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block collects up to eight interrupt sources for a small processor and presents them to the CPU through one interrupt line. A low-to-high transition on any source line is latched as a pending request. A software-written mask register can hold back any source. Among the unmasked pending requests, the lowest-numbered line wins.

The CPU answers the interrupt line with a one-cycle acknowledge pulse. In that same cycle it reads the vector output, which is a programmable base plus the winning line number. The acknowledge moves the winning request from pending to in service. While a line is in service, only strictly higher-priority lines can interrupt again, so handlers nest by priority. Software ends a handler by writing an end-of-interrupt command, which retires the highest-priority line in service.

A two-address register port carries the commands and the mask. A separate strobe loads the vector base.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the interrupt line is low, the mask reads 0xFF, the pending and in-service registers read 0x00, the vector base is 0x08 and a read at address 0 returns the pending register.
- R2: Only a low-to-high transition on `irq_in[i]` sets pending bit i. A line held high does not set its bit again after that bit has been acknowledged.
- R3: A pending request whose mask bit is 1 never raises `int_o`, but its pending bit is still latched and can be read back.
- R4: Among unmasked pending requests, the one with the lowest index is chosen. While `int_o` is high, `vec_o` equals the vector base plus that index.
- R5: When `int_ack` is high while `int_o` is high, the chosen request's pending bit is cleared and its in-service bit is set at the same clock edge. Both changes are visible one cycle later.
- R6: `int_o` is high only when the chosen request's index is strictly lower than the lowest index set in the in-service register. An empty in-service register blocks nothing.
- R7: Writing 0x20 to address 0 clears the lowest-index bit set in the in-service register. Other values written to address 0 clear nothing.
- R8: A write with `base_we` loads the vector base from `base_wdata` with its three low bits forced to zero.
- R9: Writing 0x0A to address 0 makes reads at address 0 return the pending register. Writing 0x0B makes them return the in-service register. Address 1 always reads and writes the mask.
- R10: An `int_ack` pulse while `int_o` is low changes neither the pending nor the in-service register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Interrupt source lines; index 0 has the highest priority |
| reg_we | input | 1 | Register port write strobe |
| reg_addr | input | 1 | 0 = command/status, 1 = mask |
| reg_wdata | input | 8 | Register port write data |
| reg_rdata | output | 8 | Register port read data (combinational from `reg_addr`) |
| base_we | input | 1 | Vector base write strobe |
| base_wdata | input | 8 | Vector base value; low three bits are ignored |
| int_o | output | 1 | Interrupt request to the CPU |
| int_ack | input | 1 | One-cycle acknowledge from the CPU |
| vec_o | output | 8 | Vector for the chosen request; valid while `int_o` is high |

## Verification
The in-service and end-of-interrupt properties assume that software does not issue an end-of-interrupt command in the same cycle as an acknowledge. The acknowledge property also assumes that a new rising edge on the line being acknowledged does not land in that same cycle. The bench never combines these events. Each source line is raised only once per test phase, and it is dropped before it is raised again. Acknowledge pulses last a single cycle. The stimulus still sends one acknowledge while the interrupt line is low, because that case is part of the required behaviour.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter logic [7:0] RST_BASE = 8'h08,
  parameter logic [7:0] CMD_EOI  = 8'h20,
  parameter logic [7:0] CMD_RDP  = 8'h0A,
  parameter logic [7:0] CMD_RDS  = 8'h0B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irq_in,
  input  logic       reg_we,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       base_we,
  input  logic [7:0] base_wdata,
  output logic       int_o,
  input  logic       int_ack,
  output logic [7:0] vec_o
);

  localparam logic [3:0] NONE = 4'd8;

  logic [7:0] irr_q, isr_q, imr_q, base_q, prev_q;
  logic       rd_svc_q;

  function automatic logic [3:0] first_set(input logic [7:0] v);
    logic [3:0] r;
    r = NONE;
    for (int i = 7; i >= 0; i--)
      if (v[i]) r = 4'(i);
    return r;
  endfunction

  logic [3:0] pend_idx, svc_idx;
  logic [7:0] ack_clr, eoi_clr, irr_d, isr_d;
  logic       ack_go, cmd_wr, eoi;

  assign pend_idx = first_set(irr_q & ~imr_q);
  assign svc_idx  = first_set(isr_q);
  assign int_o    = (pend_idx != NONE) && (pend_idx < svc_idx);
  assign vec_o    = base_q | {5'b0, pend_idx[2:0]};

  assign ack_go  = int_ack & int_o;
  assign ack_clr = ack_go ? (8'h01 << pend_idx[2:0]) : 8'h00;
  assign cmd_wr  = reg_we & ~reg_addr;
  assign eoi     = cmd_wr && (reg_wdata == CMD_EOI);
  assign eoi_clr = (eoi && svc_idx != NONE) ? (8'h01 << svc_idx[2:0]) : 8'h00;

  assign irr_d = (irr_q & ~ack_clr) | (irq_in & ~prev_q);
  assign isr_d = (isr_q | ack_clr) & ~eoi_clr;

  assign reg_rdata = reg_addr ? imr_q : (rd_svc_q ? isr_q : irr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q    <= 8'h00;
      isr_q    <= 8'h00;
      imr_q    <= 8'hFF;
      base_q   <= {RST_BASE[7:3], 3'b000};
      prev_q   <= 8'h00;
      rd_svc_q <= 1'b0;
    end else begin
      irr_q  <= irr_d;
      isr_q  <= isr_d;
      prev_q <= irq_in;
      if (reg_we && reg_addr) imr_q <= reg_wdata;
      if (base_we) base_q <= {base_wdata[7:3], 3'b000};
      if (cmd_wr && reg_wdata == CMD_RDP) rd_svc_q <= 1'b0;
      if (cmd_wr && reg_wdata == CMD_RDS) rd_svc_q <= 1'b1;
    end
  end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       int_o,
  input logic       int_ack,
  input logic [7:0] vec_o,
  input logic       reg_we,
  input logic       reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] irr_q,
  input logic [7:0] isr_q,
  input logic [7:0] imr_q
);
  logic [7:0] upto, above;
  logic       cmd_wr;
  assign upto   = (8'h02 << vec_o[2:0]) - 8'h01;
  assign above  = (8'h01 << vec_o[2:0]) - 8'h01;
  assign cmd_wr = reg_we & ~reg_addr;

  // R3
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> !imr_q[vec_o[2:0]] && irr_q[vec_o[2:0]]);

  // R4
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> ((irr_q & ~imr_q & above) == 8'h00));

  // R6
  nest_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> ((isr_q & upto) == 8'h00));

  // R5
  ack_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_o && !cmd_wr) |=> isr_q[$past(vec_o[2:0])]);

  // R7
  eoi_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && reg_wdata == 8'h20 && isr_q != 8'h00 && !int_ack)
      |=> $countones(isr_q) == $countones($past(isr_q)) - 1);

  // R10
  stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_o && !cmd_wr) |=> $stable(isr_q));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .int_o(int_o), .int_ack(int_ack), .vec_o(vec_o),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .irr_q(irr_q), .isr_q(isr_q), .imr_q(imr_q)
);

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/100ps
module sim_irq_prio_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] irq_in = 0, reg_wdata = 0, base_wdata = 0;
  logic reg_we = 0, reg_addr = 0, base_we = 0, int_ack = 0;
  logic [7:0] reg_rdata, vec_o;
  logic int_o;

  always #2.5 clk = ~clk;

  irq_prio_ctrl u0 (.clk, .rst_n, .irq_in, .reg_we, .reg_addr, .reg_wdata,
    .reg_rdata, .base_we, .base_wdata, .int_o, .int_ack, .vec_o);

  int tests = 0, fails = 0;
  bit done = 0;
  int m_irr, m_isr, m_imr, m_base, m_prev, m_rsel;
  logic [7:0] irqv = 0;

  function automatic int low_idx(int v);
    for (int i = 0; i < 8; i++) if ((v >> i) & 1) return i;
    return 8;
  endfunction

  task automatic check(string tag, string what, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  task automatic step(bit we, bit adr, int wd, bit bwe, int bd, bit ack, string tag);
    int p, s, e_int, clr, rise;
    irq_in = irqv; reg_we = we; reg_addr = adr; reg_wdata = 8'(wd);
    base_we = bwe; base_wdata = 8'(bd); int_ack = ack;
    #1;
    p = low_idx(m_irr & ~m_imr);
    s = low_idx(m_isr);
    e_int = (p < 8 && p < s) ? 1 : 0;
    check(tag, "int_o", int'(int_o), e_int);
    if (e_int == 1) check(tag, "vec_o", int'(vec_o), (m_base + p) & 255);
    check(tag, "reg_rdata", int'(reg_rdata), adr ? m_imr : (m_rsel ? m_isr : m_irr));
    @(posedge clk);
    rise = int'(irqv) & ~m_prev & 255;
    clr = 0;
    if (we && !adr && wd == 32 && s < 8) clr = 1 << s;
    if (ack && e_int == 1) begin
      m_irr = m_irr & ~(1 << p);
      m_isr = m_isr | (1 << p);
    end
    m_isr = m_isr & ~clr;
    m_irr = m_irr | rise;
    if (we && !adr && wd == 10) m_rsel = 0;
    if (we && !adr && wd == 11) m_rsel = 1;
    if (we && adr) m_imr = wd;
    if (bwe) m_base = (bd / 8) * 8;
    m_prev = irqv;
    @(negedge clk);
  endtask

  task automatic idle(bit adr, string tag); step(0, adr, 0, 0, 0, 0, tag); endtask
  task automatic wr(bit adr, int d, string tag); step(1, adr, d, 0, 0, 0, tag); endtask
  task automatic ack(string tag); step(0, 0, 0, 0, 0, 1, tag); endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired before end of run");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    m_irr = 0; m_isr = 0; m_imr = 255; m_base = 8; m_prev = 0; m_rsel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    idle(1, "R1"); idle(0, "R1");
    // R3 masked request latched but quiet
    irqv = 8'h08; idle(0, "R3"); idle(0, "R3"); idle(0, "R3");
    wr(1, 8'h00, "R3"); idle(0, "R4");
    // R4 lower index wins
    irqv = 8'h2A; idle(0, "R4"); idle(0, "R4");
    // R5 acknowledge moves line 1 to in service
    ack("R5"); idle(0, "R5");
    wr(0, 8'h0B, "R9"); idle(0, "R9"); idle(1, "R9");
    // R6 lower lines blocked; line 0 nests
    idle(0, "R6");
    irqv = 8'h2B; idle(0, "R6"); idle(0, "R6");
    ack("R6"); idle(0, "R6");
    // R7 end of interrupt
    wr(0, 8'h21, "R7"); idle(0, "R7");
    wr(0, 8'h20, "R7"); idle(0, "R7");
    wr(0, 8'h20, "R7"); idle(0, "R7");
    wr(0, 8'h0A, "R9"); idle(0, "R9");
    // R8 vector base
    step(0, 0, 0, 1, 8'h47, 0, "R8"); idle(0, "R8");
    step(0, 0, 0, 1, 8'hF8, 0, "R8"); idle(0, "R8");
    // R10 acknowledge without request
    wr(1, 8'hFF, "R10"); ack("R10"); idle(0, "R10");
    wr(0, 8'h0B, "R10"); idle(0, "R10");
    wr(0, 8'h0A, "R10"); idle(0, "R10");
    wr(1, 8'h00, "R10");
    // R2 held level does not retrigger after acknowledge
    ack("R2"); idle(0, "R2"); idle(0, "R2");
    ack("R2"); idle(0, "R2"); idle(0, "R2");
    irqv = 8'h00; idle(0, "R2"); idle(0, "R2");
    irqv = 8'h08; idle(0, "R2"); idle(0, "R2");
    for (int k = 0; k < 4; k++) begin
      ack("R5"); wr(0, 8'h20, "R7"); idle(0, "R6");
    end
    wr(0, 8'h0B, "R9"); idle(0, "R9"); idle(1, "R9");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule